// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the CPU-facing register file of a four-channel DMA controller. A processor reaches it through an 8-bit I/O port space. For every channel it keeps a 16-bit starting address, a 16-bit transfer count, a mode byte and an 8-bit page value that extends the address to 24 bits. It also keeps a four-bit channel mask. The programmed values, the mask, two decoded mode flags and one-cycle load strobes go out to a separate transfer engine. When software reads an address or count port, the block returns the engine's live current value.

Each 16-bit address or count value passes through a single 8-bit port. An internal byte pointer decides whether an access moves the low byte or the high byte. Every access to one of these ports flips the pointer. Software puts the pointer back on the low byte by writing any value to a dedicated clear port.

Page registers are decoded from a separate select. The system decode places them at scattered I/O addresses, so they sit outside the controller's offset space.

Top module: `dma_chan_regfile`

## Requirements
- R1: A synchronous active-high reset masks all four channels (`chan_mask` = 4'b1111). It zeroes every base address, base count, mode and page register and clears `rdata` to 0. It also puts the byte pointer on the low byte.
- R2: With `cs` high, offset `addr` = 2n selects the address port of channel n and offset 2n+1 selects its count port, for n = 0..3.
- R3: Every read or write at offsets 0..7 moves one byte and then flips the byte pointer. The low byte (bits 7:0) is moved while the pointer is clear, and the high byte (bits 15:8) while it is set.
- R4: A write to an address or count port stores `wdata` into the selected byte of that channel's base register. In the next cycle it raises exactly one bit of `load_addr` or `load_cnt` (bit n for channel n) for one cycle, so the engine can reload its current copy.
- R5: A write to offset 12 with any data value clears the byte pointer. The next access at offsets 0..7 then moves the low byte.
- R6: A write to offset 10 updates one mask bit. `wdata[1:0]` selects the channel. `wdata[2]`=1 masks that channel and `wdata[2]`=0 unmasks it. The other mask bits keep their values.
- R7: A write to offset 11 stores the whole byte as the mode of the channel named by `wdata[1:0]`. Bits 3:2 of the mode byte are the direction (01 = into memory, 10 = out of memory). `auto_init[n]` follows mode bit 4, and `cascade[n]` is 1 exactly when mode bits 7:6 are 11.
- R8: A read (`rd_en` with `wr_en` low) at an address or count port returns the selected byte of `cur_addr` or `cur_cnt` for that channel. The value appears on `rdata` one cycle after the read and holds until the next read.
- R9: With `pg_sel` high and `cs` low, `addr[1:0]` picks a page register. A write stores `wdata` there, and a read returns it one cycle later. Page accesses leave the byte pointer unchanged.
- R10: Writes at offsets 8, 9, 13, 14 and 15 change no register and leave the byte pointer unchanged. Reads at offsets 8..15 return 0 and also leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Controller port select |
| pg_sel | input | 1 | Page register select (ignored while `cs` is high) |
| addr | input | 4 | Port offset; `addr[1:0]` picks the channel for page accesses |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cur_addr | input | 64 | Engine current address, channel n in bits 16n+15:16n |
| cur_cnt | input | 64 | Engine current count, channel n in bits 16n+15:16n |
| base_addr | output | 64 | Programmed base addresses, packed per channel |
| base_cnt | output | 64 | Programmed base counts, packed per channel |
| page | output | 32 | Page values (address bits 23:16), channel n in bits 8n+7:8n |
| mode | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| chan_mask | output | 4 | Channel mask bits, 1 = masked |
| auto_init | output | 4 | Per-channel autoinitialise flag |
| cascade | output | 4 | Per-channel cascade type flag |
| load_addr | output | 4 | One-cycle strobe after a write to an address port |
| load_cnt | output | 4 | One-cycle strobe after a write to a count port |

## Verification
The hardest situation to reach is a byte pointer left in the middle of a pair when an unrelated access arrives. Examples are a clear write, a page access or an access to a reserved offset between the low and high halves. Reads also interleave across different channels' ports. The stimulus table strings reads of live engine values together so that the pointer state carries from one entry to the next. Directed sequences then place a clear write with non-zero data, a reserved-offset write and a mid-sequence reset right after an odd number of port accesses.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned OFS_MASK = 10;
  localparam int unsigned OFS_MODE = 11;
  localparam int unsigned OFS_CLR  = 12;

  function automatic logic mode_is_auto(input logic [7:0] m);
    return m[4];
  endfunction

  function automatic logic mode_is_cascade(input logic [7:0] m);
    return (m[7:6] == 2'b11);
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (rst || clr) hi <= 1'b0;
    else if (step)  hi <= ~hi;
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_hi,
  input  logic          wr_mode,
  input  logic          wr_page,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] base_addr,
  output logic [AW-1:0] base_cnt,
  output logic [DW-1:0] mode,
  output logic [DW-1:0] page,
  output logic          ld_addr,
  output logic          ld_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      mode      <= '0;
      page      <= '0;
      ld_addr   <= 1'b0;
      ld_cnt    <= 1'b0;
    end else begin
      ld_addr <= wr_addr;
      ld_cnt  <= wr_cnt;
      if (wr_addr) begin
        if (wr_hi) base_addr[AW-1:DW] <= wdata;
        else       base_addr[DW-1:0]  <= wdata;
      end
      if (wr_cnt) begin
        if (wr_hi) base_cnt[AW-1:DW] <= wdata;
        else       base_cnt[DW-1:0]  <= wdata;
      end
      if (wr_mode) mode <= wdata;
      if (wr_page) page <= wdata;
    end
  end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH*AW-1:0] cur_addr,
  input  logic [NCH*AW-1:0] cur_cnt,
  input  logic [NCH*DW-1:0] page,
  input  logic [CW-1:0]     ch,
  input  logic              is_cnt,
  input  logic              hi,
  input  logic              sel_port,
  input  logic              sel_page,
  output logic [DW-1:0]     rbyte
);
  logic [AW-1:0] word;
  always_comb begin
    word  = is_cnt ? cur_cnt[ch*AW +: AW] : cur_addr[ch*AW +: AW];
    rbyte = '0;
    if (sel_page)      rbyte = page[ch*DW +: DW];
    else if (sel_port) rbyte = hi ? word[AW-1:DW] : word[DW-1:0];
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 16,
  parameter int OW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              pg_sel,
  input  logic [OW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*AW-1:0] cur_addr,
  input  logic [NCH*AW-1:0] cur_cnt,
  output logic [NCH*AW-1:0] base_addr,
  output logic [NCH*AW-1:0] base_cnt,
  output logic [NCH*DW-1:0] page,
  output logic [NCH*DW-1:0] mode,
  output logic [NCH-1:0]    chan_mask,
  output logic [NCH-1:0]    auto_init,
  output logic [NCH-1:0]    cascade,
  output logic [NCH-1:0]    load_addr,
  output logic [NCH-1:0]    load_cnt
);
  localparam int CW    = $clog2(NCH);
  localparam int NPORT = 2 * NCH;

  logic          ptr_hi;
  logic          do_wr, do_rd;
  logic          sel_port, sel_page;
  logic [CW-1:0] port_ch, page_ch;
  logic          port_cnt;
  logic          wr_port, wr_mask, wr_mode, wr_clr, wr_page;
  logic [DW-1:0] rbyte;

  assign do_wr    = wr_en;
  assign do_rd    = rd_en && !wr_en;
  assign sel_port = cs && (int'(addr) < NPORT);
  assign sel_page = pg_sel && !cs;
  assign port_ch  = addr[CW:1];
  assign port_cnt = addr[0];
  assign page_ch  = addr[CW-1:0];
  assign wr_port  = sel_port && do_wr;
  assign wr_mask  = cs && do_wr && (int'(addr) == OFS_MASK);
  assign wr_mode  = cs && do_wr && (int'(addr) == OFS_MODE);
  assign wr_clr   = cs && do_wr && (int'(addr) == OFS_CLR);
  assign wr_page  = sel_page && do_wr;

  dma_byte_ptr u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (wr_clr),
    .step (sel_port && (do_wr || do_rd)),
    .hi   (ptr_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [DW-1:0] m;
    dma_chan_slot #(.DW(DW), .AW(AW)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_addr   (wr_port && !port_cnt && (port_ch == CW'(i))),
      .wr_cnt    (wr_port &&  port_cnt && (port_ch == CW'(i))),
      .wr_hi     (ptr_hi),
      .wr_mode   (wr_mode && (wdata[CW-1:0] == CW'(i))),
      .wr_page   (wr_page && (page_ch == CW'(i))),
      .wdata     (wdata),
      .base_addr (base_addr[i*AW +: AW]),
      .base_cnt  (base_cnt[i*AW +: AW]),
      .mode      (m),
      .page      (page[i*DW +: DW]),
      .ld_addr   (load_addr[i]),
      .ld_cnt    (load_cnt[i])
    );
    assign mode[i*DW +: DW] = m;
    assign auto_init[i]     = mode_is_auto(m);
    assign cascade[i]       = mode_is_cascade(m);
  end

  always_ff @(posedge clk) begin
    if (rst) chan_mask <= '1;
    else if (wr_mask) chan_mask[wdata[CW-1:0]] <= wdata[2];
  end

  dma_rd_mux #(.NCH(NCH), .DW(DW), .AW(AW)) u_mux (
    .cur_addr (cur_addr),
    .cur_cnt  (cur_cnt),
    .page     (page),
    .ch       (sel_page ? page_ch : port_ch),
    .is_cnt   (port_cnt),
    .hi       (ptr_hi),
    .sel_port (sel_port),
    .sel_page (sel_page),
    .rbyte    (rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (do_rd && (cs || sel_page)) rdata <= rbyte;
  end
endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int OW  = 4,
  localparam int CW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic           cs,
  input logic           pg_sel,
  input logic [OW-1:0]  addr,
  input logic           wr_en,
  input logic           rd_en,
  input logic [DW-1:0]  wdata,
  input logic [DW-1:0]  rdata,
  input logic [NCH-1:0] chan_mask,
  input logic [NCH-1:0] load_addr,
  input logic [NCH-1:0] load_cnt,
  input logic           ptr_hi
);
  logic port_acc;
  assign port_acc = cs && (wr_en || rd_en) && (int'(addr) < 2*NCH);

  AST_RESET_MASKED: assert property (@(posedge clk)
    rst |=> (chan_mask == '1 && !ptr_hi && rdata == '0)); // R1

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    port_acc |=> (ptr_hi != $past(ptr_hi))); // R3

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (port_acc && wr_en) |=> ($countones({load_addr, load_cnt}) == 1)); // R4

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    !(port_acc && wr_en) |=> ({load_addr, load_cnt} == '0)); // R4

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en && addr == OW'(12)) |=> !ptr_hi); // R5

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en && addr == OW'(10)) |=>
      (chan_mask[$past(wdata[CW-1:0])] == $past(wdata[2]))); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !wr_en) |=> $stable(rdata)); // R8

  AST_PAGE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (pg_sel && !cs) |=> $stable(ptr_hi)); // R9
endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(.NCH(NCH), .DW(DW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs        (cs),
  .pg_sel    (pg_sel),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .chan_mask (chan_mask),
  .load_addr (load_addr),
  .load_cnt  (load_cnt),
  .ptr_hi    (ptr_hi)
);

// File: tb/dma_chan_regfile_bench.sv
`timescale 1ns/1ps
module dma_chan_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, pg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [63:0] cur_addr, cur_cnt, base_addr, base_cnt;
  logic [31:0] page, mode;
  logic [3:0]  chan_mask, auto_init, cascade, load_addr, load_cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] ld_a, ld_c;
  logic [7:0] rd_val;

  always #2.5 clk = ~clk;

  // engine current values: ch n address = C1D0 + n*0101, count = 5060 + n*0101
  assign cur_addr = {16'hC4D3, 16'hC3D2, 16'hC2D1, 16'hC1D0};
  assign cur_cnt  = {16'h5363, 16'h5262, 16'h5161, 16'h5060};

  dma_chan_regfile u_dma_chan_regfile (
    .clk(clk), .rst(rst), .cs(cs), .pg_sel(pg_sel), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .base_addr(base_addr),
    .base_cnt(base_cnt), .page(page), .mode(mode), .chan_mask(chan_mask),
    .auto_init(auto_init), .cascade(cascade), .load_addr(load_addr),
    .load_cnt(load_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic bus_wr(input logic pg, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = !pg; pg_sel = pg; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    cs = 1'b0; pg_sel = 1'b0; wr_en = 1'b0;
    ld_a = load_addr; ld_c = load_cnt;
  endtask

  task automatic bus_rd(input logic pg, input logic [3:0] a);
    @(negedge clk);
    cs = !pg; pg_sel = pg; addr = a; rd_en = 1'b1;
    @(negedge clk);
    cs = 1'b0; pg_sel = 1'b0; rd_en = 1'b0;
    rd_val = rdata;
  endtask

  // entry: {is_read, page, offset, wdata, expected rdata}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd12, 8'h00, 8'h00},  // clear pointer
    {1'b1, 1'b0, 4'd0,  8'h00, 8'hD0},  // ch0 addr low
    {1'b1, 1'b0, 4'd0,  8'h00, 8'hC1},  // ch0 addr high
    {1'b1, 1'b0, 4'd3,  8'h00, 8'h61},  // ch1 count low
    {1'b0, 1'b0, 4'd12, 8'h00, 8'h00},  // clear mid-pair
    {1'b1, 1'b0, 4'd3,  8'h00, 8'h61},
    {1'b1, 1'b0, 4'd3,  8'h00, 8'h51},
    {1'b1, 1'b0, 4'd6,  8'h00, 8'hD3},  // ch3 addr
    {1'b1, 1'b0, 4'd6,  8'h00, 8'hC4},
    {1'b1, 1'b0, 4'd14, 8'h00, 8'h00},  // reserved read
    {1'b1, 1'b0, 4'd7,  8'h00, 8'h63},  // ch3 count, still low
    {1'b1, 1'b0, 4'd7,  8'h00, 8'h53},
    {1'b0, 1'b1, 4'd2,  8'h7E, 8'h00},  // page ch2 write
    {1'b1, 1'b1, 4'd2,  8'h00, 8'h7E},
    {1'b1, 1'b0, 4'd5,  8'h00, 8'h62},  // ch2 count, page left pointer low
    {1'b1, 1'b0, 4'd4,  8'h00, 8'hC3},  // ch2 addr, high byte
    {1'b1, 1'b0, 4'd9,  8'h00, 8'h00},
    {1'b1, 1'b0, 4'd2,  8'h00, 8'hD1}   // ch1 addr, low again
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mask", chan_mask, 4'hF);
    chk("R1 base_addr", base_addr, 64'h0);
    chk("R1 base_cnt", base_cnt, 64'h0);
    chk("R1 mode/page", {mode, page}, 64'h0);
    chk("R1 rdata", rdata, 8'h00);
    rst = 1'b0;
    bus_rd(1'b0, 4'd0);
    chk("R1 pointer low after reset", rd_val, 8'hD0);
    bus_wr(1'b0, 4'd12, 8'h00);

    // R2 R3 R8 R9 R10 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        bus_rd(VEC[i][20], VEC[i][19:16]);
        chk($sformatf("R8 R3 R2 R9 R10 vec%0d", i), rd_val, VEC[i][7:0]);
      end else begin
        bus_wr(VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
      end
    end
    chk("R9 page value", page, 32'h007E_0000);

    // R4 address/count writes
    bus_wr(1'b0, 4'd12, 8'h00);
    bus_wr(1'b0, 4'd4, 8'h34);
    chk("R4 load_addr strobe", {ld_a, ld_c}, 8'b0100_0000);
    chk("R4 low byte", base_addr[47:32], 16'h0034);
    bus_wr(1'b0, 4'd4, 8'h12);
    chk("R4 high byte", base_addr[47:32], 16'h1234);
    @(negedge clk);
    chk("R4 strobe one cycle", {load_addr, load_cnt}, 8'h00);
    bus_wr(1'b0, 4'd1, 8'hEF);
    bus_wr(1'b0, 4'd1, 8'hBE);
    chk("R4 load_cnt strobe", {ld_a, ld_c}, 8'b0000_0001);
    chk("R4 count ch0", base_cnt[15:0], 16'hBEEF);
    chk("R4 other channels", {base_addr[31:0], base_addr[63:48]}, 48'h0);

    // R5 clear with non-zero data mid-pair
    bus_wr(1'b0, 4'd6, 8'hAA);
    bus_wr(1'b0, 4'd12, 8'hFF);
    bus_wr(1'b0, 4'd6, 8'h55);
    chk("R5 clear forces low byte", base_addr[63:48], 16'h0055);

    // R6 single mask
    bus_wr(1'b0, 4'd10, 8'h01);
    chk("R6 unmask ch1", chan_mask, 4'b1101);
    bus_wr(1'b0, 4'd10, 8'hFA);
    chk("R6 unmask ch2 upper bits ignored", chan_mask, 4'b1001);
    bus_wr(1'b0, 4'd10, 8'h05);
    chk("R6 mask ch1", chan_mask, 4'b1011);

    // R7 mode: 5A = ch2, dir 10, auto, single; C3 = ch3 cascade
    bus_wr(1'b0, 4'd11, 8'h5A);
    chk("R7 mode ch2", mode[23:16], 8'h5A);
    chk("R7 auto_init", auto_init, 4'b0100);
    bus_wr(1'b0, 4'd11, 8'hC3);
    chk("R7 cascade", {cascade, auto_init}, 8'b1000_0100);
    chk("R7 mode ch3", mode[31:24], 8'hC3);

    // R10 reserved writes ignored, pointer untouched
    bus_wr(1'b0, 4'd12, 8'h00);
    bus_wr(1'b0, 4'd13, 8'hFF);
    bus_wr(1'b0, 4'd8,  8'hFF);
    bus_wr(1'b0, 4'd15, 8'hFF);
    chk("R10 mask/mode kept", {chan_mask, mode}, {4'b1011, 32'hC35A_0000});
    bus_rd(1'b0, 4'd0);
    chk("R10 pointer unchanged", rd_val, 8'hD0);

    // R1 reset mid-pair
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid reset mask", chan_mask, 4'hF);
    chk("R1 mid reset regs", {base_addr[47:32], base_cnt[15:0], mode}, 64'h0);
    bus_rd(1'b0, 4'd2);
    chk("R1 mid reset pointer", rd_val, 8'hD1);

    done = 1;
    summary();
    $finish;
  end
endmodule